// File: doc/BRIEF.md
# Logarithmic Sign-Magnitude Arithmetic Unit

This unit does arithmetic on signed real numbers held in a logarithmic sign-magnitude form. A value is a sign bit `s` and an unsigned magnitude code `m`, and stands for (-1)^s · e^(-m/8). The magnitude is fixed point with three fractional bits, so one code step is 1/8 in the log domain. A smaller code means a larger absolute value. The all-ones code (255) stands for a value that is practically zero.

A 2-bit opcode picks the operation. Multiplication and division become a sum or a difference of magnitudes, with the signs combined by XOR. Addition keeps the dominant operand, which is the one with the smaller magnitude code. It then applies a correction read from one of two small built-in tables. When the signs agree, the bounded table for log(1+e^-Δ) shrinks the magnitude. When they differ, the table for -log(1-e^-Δ) grows the magnitude. That table has no bound near Δ = 0, so equal magnitudes with opposite signs are forced to the zero code.

Operands are taken on a clock edge where `in_valid` is high. The result and `out_valid` are registered on that same edge, so they are visible one cycle after the strobe. Opcode encoding: 00 addition, 01 multiplication, 10 division, 11 addition again.

Top module: `sml_alu`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and the result is sign 0 with magnitude 255 until the first accepted operation.
- R2: An operation accepted on a clock edge where `in_valid` is 1 makes `out_valid` 1 after that edge. After an edge where `in_valid` is 0, `out_valid` is 0 and the result holds its previous value whatever the other inputs do.
- R3: Opcode 01 (multiply) gives sign x_sign XOR y_sign and magnitude x_mag + y_mag, saturated at 255.
- R4: Opcode 10 (divide) gives sign x_sign XOR y_sign and magnitude x_mag − y_mag, clamped at 0.
- R5: For addition, if y_mag > x_mag the result sign is x_sign and the base magnitude is x_mag. Otherwise the result sign is y_sign and the base is y_mag, so a tie picks the Y operand.
- R6: Addition with equal signs gives base − round(8·ln(1+e^(−Δ/8))), clamped at 0, where Δ = |x_mag − y_mag| in code steps.
- R7: Addition with different signs and Δ > 0 gives base + round(−8·ln(1−e^(−Δ/8))), saturated at 255.
- R8: Addition with different signs and equal magnitudes gives magnitude 255, with the sign of the Y operand.
- R9: When Δ is 32 or more, the correction is zero and the addition result magnitude equals the base magnitude exactly.
- R10: Opcode 11 gives the same result as opcode 00 for the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are taken on this edge |
| op | input | 2 | 00 add, 01 multiply, 10 divide, 11 add |
| x_sign | input | 1 | Sign of the first operand |
| x_mag | input | 8 | Log magnitude of the first operand (3 fractional bits) |
| y_sign | input | 1 | Sign of the second operand |
| y_mag | input | 8 | Log magnitude of the second operand (3 fractional bits) |
| out_valid | output | 1 | Result registered from an accepted operation |
| z_sign | output | 1 | Result sign |
| z_mag | output | 8 | Result log magnitude |

## Verification
Each result is due exactly one rising edge after the edge that accepts its strobe, and it holds until the next accepted strobe. The driver applies operands on a falling edge and pushes the expected value, computed with real-valued logarithms and exponentials, into a queue. The monitor pops that value on the next falling edge, which is the first one after the capturing edge. Hold behaviour is checked on falling edges several cycles after the strobe is dropped, while the operand inputs are changed. The queue must be empty at the end, so a late or missing `out_valid` also counts as a failure.

// File: rtl/sml_pkg.sv
package sml_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_MUL     = 2'b01,
        OP_DIV     = 2'b10,
        OP_ADD_ALT = 2'b11
    } sml_op_e;

    localparam int SML_MAG_W  = 8;
    localparam int SML_IDX_W  = 5;
    localparam int SML_CORR_W = 5;

endpackage

// File: rtl/sml_corr_lut.sv
module sml_corr_lut #(
    parameter bit OPPOSITE = 1'b0,
    parameter int IDX_W    = 5,
    parameter int CORR_W   = 5
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CORR_W-1:0] corr
);

    // Entries are 8*ln(1+e^-d) (agreeing signs) or -8*ln(1-e^-d)
    // (differing signs), with d = idx/8, rounded to the nearest code.
    function automatic logic [CORR_W-1:0] same_tab(input int i);
        case (i)
            0:              return CORR_W'(6);
            1, 2:           return CORR_W'(5);
            3, 4:           return CORR_W'(4);
            5, 6, 7, 8:     return CORR_W'(3);
            9, 10, 11, 12:  return CORR_W'(2);
            13, 14, 15, 16, 17, 18, 19, 20, 21: return CORR_W'(1);
            default:        return '0;
        endcase
    endfunction

    function automatic logic [CORR_W-1:0] opp_tab(input int i);
        case (i)
            0:              return '1;
            1:              return CORR_W'(17);
            2:              return CORR_W'(12);
            3:              return CORR_W'(9);
            4:              return CORR_W'(7);
            5:              return CORR_W'(6);
            6:              return CORR_W'(5);
            7, 8:           return CORR_W'(4);
            9, 10:          return CORR_W'(3);
            11, 12, 13, 14: return CORR_W'(2);
            15, 16, 17, 18, 19, 20, 21, 22: return CORR_W'(1);
            default:        return '0;
        endcase
    endfunction

    generate
        if (OPPOSITE) begin : g_opp
            always_comb corr = opp_tab(int'(idx));
        end else begin : g_same
            always_comb corr = same_tab(int'(idx));
        end
    endgenerate

endmodule

// File: rtl/sml_add.sv
module sml_add #(
    parameter int MAG_W  = 8,
    parameter int IDX_W  = 5,
    parameter int CORR_W = 5
) (
    input  logic             xs,
    input  logic [MAG_W-1:0] xm,
    input  logic             ys,
    input  logic [MAG_W-1:0] ym,
    output logic             zs,
    output logic [MAG_W-1:0] zm
);

    localparam int               DEPTH   = 1 << IDX_W;
    localparam logic [MAG_W-1:0] MAG_MAX = '1;

    logic              pick_x;
    logic [MAG_W-1:0]  base;
    logic [MAG_W-1:0]  delta;
    logic [IDX_W-1:0]  idx;
    logic [CORR_W-1:0] c_same;
    logic [CORR_W-1:0] c_opp;
    logic [MAG_W:0]    grown;

    always_comb begin
        pick_x = (ym > xm);
        base   = pick_x ? xm : ym;
        zs     = pick_x ? xs : ys;
        delta  = pick_x ? (ym - xm) : (xm - ym);
        idx    = (delta > MAG_W'(DEPTH - 1)) ? IDX_W'(DEPTH - 1) : delta[IDX_W-1:0];
    end

    sml_corr_lut #(.OPPOSITE(1'b0), .IDX_W(IDX_W), .CORR_W(CORR_W)) u_lut_same (
        .idx  (idx),
        .corr (c_same)
    );

    sml_corr_lut #(.OPPOSITE(1'b1), .IDX_W(IDX_W), .CORR_W(CORR_W)) u_lut_opp (
        .idx  (idx),
        .corr (c_opp)
    );

    always_comb begin
        grown = {1'b0, base} + (MAG_W + 1)'(c_opp);
        if (xs == ys) begin
            zm = (base > MAG_W'(c_same)) ? (base - MAG_W'(c_same)) : '0;
        end else if (delta == '0) begin
            zm = MAG_MAX;
        end else if (grown[MAG_W]) begin
            zm = MAG_MAX;
        end else begin
            zm = grown[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/sml_muldiv.sv
module sml_muldiv #(
    parameter int MAG_W = 8
) (
    input  logic             is_div,
    input  logic             xs,
    input  logic [MAG_W-1:0] xm,
    input  logic             ys,
    input  logic [MAG_W-1:0] ym,
    output logic             zs,
    output logic [MAG_W-1:0] zm
);

    localparam logic [MAG_W-1:0] MAG_MAX = '1;

    logic [MAG_W:0] sum;
    logic [MAG_W:0] diff;

    always_comb begin
        zs   = xs ^ ys;
        sum  = {1'b0, xm} + {1'b0, ym};
        diff = {1'b0, xm} - {1'b0, ym};
        if (is_div) begin
            zm = diff[MAG_W] ? '0 : diff[MAG_W-1:0];
        end else begin
            zm = sum[MAG_W] ? MAG_MAX : sum[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/sml_alu.sv
module sml_alu
    import sml_pkg::*;
#(
    parameter int MAG_W  = SML_MAG_W,
    parameter int IDX_W  = SML_IDX_W,
    parameter int CORR_W = SML_CORR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic             x_sign,
    input  logic [MAG_W-1:0] x_mag,
    input  logic             y_sign,
    input  logic [MAG_W-1:0] y_mag,
    output logic             out_valid,
    output logic             z_sign,
    output logic [MAG_W-1:0] z_mag
);

    sml_op_e          op_e;
    logic             add_s;
    logic [MAG_W-1:0] add_m;
    logic             md_s;
    logic [MAG_W-1:0] md_m;
    logic             nxt_s;
    logic [MAG_W-1:0] nxt_m;

    assign op_e = sml_op_e'(op);

    sml_add #(.MAG_W(MAG_W), .IDX_W(IDX_W), .CORR_W(CORR_W)) u_add (
        .xs (x_sign),
        .xm (x_mag),
        .ys (y_sign),
        .ym (y_mag),
        .zs (add_s),
        .zm (add_m)
    );

    sml_muldiv #(.MAG_W(MAG_W)) u_muldiv (
        .is_div (op_e == OP_DIV),
        .xs     (x_sign),
        .xm     (x_mag),
        .ys     (y_sign),
        .ym     (y_mag),
        .zs     (md_s),
        .zm     (md_m)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_ADD_ALT: begin
                nxt_s = add_s;
                nxt_m = add_m;
            end
            OP_MUL, OP_DIV: begin
                nxt_s = md_s;
                nxt_m = md_m;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            z_sign    <= 1'b0;
            z_mag     <= '1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                z_sign <= nxt_s;
                z_mag  <= nxt_m;
            end
        end
    end

endmodule

// File: rtl/sml_alu_chk.sv
module sml_alu_chk #(
    parameter int MAG_W = 8,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic             x_sign,
    input logic [MAG_W-1:0] x_mag,
    input logic             y_sign,
    input logic [MAG_W-1:0] y_mag,
    input logic             out_valid,
    input logic             z_sign,
    input logic [MAG_W-1:0] z_mag
);

    localparam int DEPTH = 1 << IDX_W;

    logic             c_add;
    logic [MAG_W-1:0] c_min;
    logic [MAG_W-1:0] c_dist;

    assign c_add  = (op == 2'b00) || (op == 2'b11);
    assign c_min  = (y_mag > x_mag) ? x_mag : y_mag;
    assign c_dist = (y_mag > x_mag) ? (y_mag - x_mag) : (x_mag - y_mag);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(z_sign) && $stable(z_mag)));

    a_r3_mul_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01) |=> (z_sign == $past(x_sign ^ y_sign)));

    a_r4_div_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10) |=> (z_sign == $past(x_sign ^ y_sign)));

    a_r5_pick_x: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_add && (y_mag > x_mag)) |=> (z_sign == $past(x_sign)));

    a_r5_pick_y: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_add && !(y_mag > x_mag)) |=> (z_sign == $past(y_sign)));

    a_r6_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_add && (x_sign == y_sign)) |=> (z_mag <= $past(c_min)));

    a_r7_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_add && (x_sign != y_sign)) |=> (z_mag >= $past(c_min)));

    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_add && (x_sign != y_sign) && (x_mag == y_mag)) |=> (z_mag == '1));

    a_r9_far_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_add && (c_dist >= MAG_W'(DEPTH))) |=> (z_mag == $past(c_min)));

endmodule

bind sml_alu sml_alu_chk #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .x_sign    (x_sign),
    .x_mag     (x_mag),
    .y_sign    (y_sign),
    .y_mag     (y_mag),
    .out_valid (out_valid),
    .z_sign    (z_sign),
    .z_mag     (z_mag)
);

// File: tb/sim_sml_alu.sv
`timescale 1ns/1ps
module sim_sml_alu;

    typedef struct {
        logic       s;
        logic [7:0] m;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic       x_sign = 1'b0;
    logic [7:0] x_mag = 8'd0;
    logic       y_sign = 1'b0;
    logic [7:0] y_mag = 8'd0;
    logic       out_valid;
    logic       z_sign;
    logic [7:0] z_mag;

    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t last_e;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    sml_alu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .x_sign    (x_sign),
        .x_mag     (x_mag),
        .y_sign    (y_sign),
        .y_mag     (y_mag),
        .out_valid (out_valid),
        .z_sign    (z_sign),
        .z_mag     (z_mag)
    );

    function automatic exp_t ref_calc(input logic [1:0] o, input logic xs, input int xm,
                                      input logic ys, input int ym);
        exp_t e;
        real  r;
        int   base;
        int   d;
        int   v;
        if (o == 2'b01) begin
            e.s = xs ^ ys;
            v   = xm + ym;
            e.m = (v > 255) ? 8'd255 : 8'(v);
        end else if (o == 2'b10) begin
            e.s = xs ^ ys;
            v   = xm - ym;
            e.m = (v < 0) ? 8'd0 : 8'(v);
        end else begin
            base = (ym > xm) ? xm : ym;
            e.s  = (ym > xm) ? xs : ys;
            d    = (xm > ym) ? (xm - ym) : (ym - xm);
            if (xs == ys) begin
                r = base - 8.0 * $ln(1.0 + $exp(-d / 8.0));
                v = (r < 0.0) ? 0 : $rtoi(r + 0.5);
            end else if (d == 0) begin
                v = 255;
            end else begin
                r = base - 8.0 * $ln(1.0 - $exp(-d / 8.0));
                v = $rtoi(r + 0.5);
                if (v > 255) v = 255;
            end
            e.m = 8'(v);
        end
        e.req = "";
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic s_act, input logic [7:0] m_act,
                         input logic s_exp, input logic [7:0] m_exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual sign=%0d mag=%0d expected sign=%0d mag=%0d",
                     req, s_act, m_act, s_exp, m_exp);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic xs, input logic [7:0] xm,
                         input logic ys, input logic [7:0] ym, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        op       = o;
        x_sign   = xs;
        x_mag    = xm;
        y_sign   = ys;
        y_mag    = ym;
        e        = ref_calc(o, xs, int'(xm), ys, int'(ym));
        e.req    = req;
        q.push_back(e);
        last_e   = e;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string req_of(input logic [1:0] o, input logic xs, input logic ys);
        if (o == 2'b01) return "R3";
        if (o == 2'b10) return "R4";
        if (o == 2'b11) return "R10";
        return (xs == ys) ? "R6" : "R7";
    endfunction

    // Monitor: results are due at the first falling edge after the capturing edge.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", z_sign, z_mag, 1'b0, 8'd0);
            end else begin
                e = q.pop_front();
                check((z_sign === e.s) && (z_mag === e.m), e.req, z_sign, z_mag, e.s, e.m);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, strobe ignored while in reset
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && z_sign === 1'b0 && z_mag === 8'd255, "R1 in reset",
              z_sign, z_mag, 1'b0, 8'd255);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0 && z_sign === 1'b0 && z_mag === 8'd255, "R1 after reset",
              z_sign, z_mag, 1'b0, 8'd255);

        // R3 multiply
        drive(2'b01, 1'b0, 8'd10, 1'b1, 8'd20, "R3 mul");
        drive(2'b01, 1'b0, 8'd200, 1'b0, 8'd100, "R3 mul saturate");
        // R4 divide
        drive(2'b10, 1'b1, 8'd50, 1'b1, 8'd20, "R4 div");
        drive(2'b10, 1'b0, 8'd10, 1'b1, 8'd40, "R4 div clamp");
        // R5 selection
        drive(2'b00, 1'b1, 8'd10, 1'b0, 8'd40, "R5 pick x");
        drive(2'b00, 1'b0, 8'd90, 1'b1, 8'd40, "R5 pick y");
        // R6 same sign
        drive(2'b00, 1'b0, 8'd40, 1'b0, 8'd40, "R6 equal");
        drive(2'b00, 1'b1, 8'd40, 1'b1, 8'd48, "R6 delta 8");
        drive(2'b00, 1'b0, 8'd3, 1'b0, 8'd3, "R6 clamp zero");
        // R7 opposite sign
        drive(2'b00, 1'b0, 8'd40, 1'b1, 8'd48, "R7 delta 8");
        drive(2'b00, 1'b0, 8'd40, 1'b1, 8'd41, "R7 delta 1");
        drive(2'b00, 1'b1, 8'd250, 1'b0, 8'd251, "R7 saturate");
        // R8 cancellation
        drive(2'b00, 1'b0, 8'd40, 1'b1, 8'd40, "R8 cancel");
        drive(2'b00, 1'b1, 8'd0, 1'b0, 8'd0, "R8 cancel at zero code");
        // R9 beyond table
        drive(2'b00, 1'b0, 8'd10, 1'b0, 8'd42, "R9 same far");
        drive(2'b00, 1'b0, 8'd10, 1'b1, 8'd42, "R9 opposite far");
        drive(2'b00, 1'b1, 8'd230, 1'b0, 8'd30, "R9 very far");
        // R10 alternate add code
        drive(2'b11, 1'b0, 8'd40, 1'b1, 8'd48, "R10 alt add opposite");
        drive(2'b11, 1'b1, 8'd20, 1'b1, 8'd21, "R10 alt add same");
        idle();

        // R2: hold while idle with changing operands
        x_mag = 8'd7; y_mag = 8'd99; op = 2'b01; x_sign = ~x_sign;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && z_sign === last_e.s && z_mag === last_e.m, "R2 hold",
              z_sign, z_mag, last_e.s, last_e.m);

        // Sweep of all opcodes with pseudo-random operands, back to back
        for (int i = 0; i < 600; i++) begin
            logic [1:0] o;
            logic       xs;
            logic       ys;
            logic [7:0] xm;
            logic [7:0] ym;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            o  = lcg[31:30];
            xs = lcg[29];
            ys = lcg[28];
            xm = lcg[27:20];
            ym = (lcg[19]) ? (xm + 8'(lcg[5:0]) - 8'd16) : lcg[15:8];
            drive(o, xs, xm, ys, ym, req_of(o, xs, ys));
            if (lcg[3:0] == 4'd0) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2 all results delivered", 1'b0, 8'(q.size()), 1'b0, 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule